// File: doc/BRIEF.md
# Coprocessor-0 Register Access Unit

This block holds the system-control coprocessor registers of a 64-bit core and carries out the instructions that move values between those registers and the general register file. Each cycle it looks at one instruction word with its valid strobe and a 64-bit source operand already read from the general registers. When the word is a coprocessor-0 move, the block either returns a read value with a general-register write enable and destination index, or updates one of its registers from the source operand.

The registers that hold state are a 32-bit Compare register, a 32-bit Status register and the interrupt-pending field of the Cause register. Hardware sets pending bits through a set input, and a write to Compare clears pending bit 0. The identification entries return fixed values. An access to any location that is not on the address map raises a reserved-instruction flag, and the exception code in Cause records it. The Cause view is a read-only output port. Results and flags are combinational in the cycle of the strobe, and register updates take effect at the next clock edge.

Top module: `cp0_regs_unit`

## Requirements
- R1: A word counts as a move only when valid_i is high, bits 31..26 are 010000, bits 10..3 are zero and bits 25..21 are 00000 (32-bit read), 00001 (64-bit read), 00100 (32-bit write) or 00101 (64-bit write). Any other word gives no write enable, no exception and no state change.
- R2: Coprocessor register 11, select 0 (Compare): a write stores the low 32 bits of src_i, and a 64-bit read returns it zero-extended.
- R3: pend_set_i ORs into sticky pending bits, which show on cause_o[15:8]. A write to Compare clears pending bit 0 (cause_o[8]) and wins over a set of the same bit in the same cycle. It leaves the other pending bits alone.
- R4: Register 12, select 0 (Status): a write stores the low 32 bits of src_i, and a 64-bit read returns it zero-extended.
- R5: Register 15 reads 0x400 at select 0 and zero at selects 6 and 7.
- R6: Writes to register 15 at selects 0, 6 and 7 raise no exception and change neither Compare, Status nor the pending bits.
- R7: A move to any other (register, select) pair raises rsvd_exc_o in the strobe's cycle with gpr_we_o low and no register change. From the next cycle, cause_o[6:2] reads 10.
- R8: A 32-bit read copies result bit 31 into bits 63..32. A 64-bit read returns the full zero-extended value.
- R9: After reset, Compare, Status, the pending bits and the exception code are zero.
- R10: A write move never asserts gpr_we_o. A successful read asserts gpr_we_o with gpr_idx_o equal to bits 20..16.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| valid_i | input | 1 | Instruction valid strobe |
| instr_i | input | 32 | Instruction word |
| src_i | input | 64 | Source operand from the general register file |
| pend_set_i | input | 8 | Hardware interrupt-pending set requests |
| result_o | output | 64 | Value for the general register |
| gpr_we_o | output | 1 | General-register write enable |
| gpr_idx_o | output | 5 | Destination general register |
| rsvd_exc_o | output | 1 | Reserved-instruction exception |
| cause_o | output | 32 | Cause view: pending bits 15..8, exception code 6..2 |

## Verification
The bench reads Compare back after writing a value with bit 31 set, through both the 32-bit and the 64-bit read. A design that mixed up the two extensions would return the wrong upper word in one of them. It writes Status with junk in the upper half and expects only the low word to survive. It writes to unmapped locations and to the identification entries. A design that decoded loosely would trap on the identification entries, let a trapped write through, or leave the exception code stale. Pending bit 0 is set and cleared with a Compare write in the same cycle, to catch the wrong priority or a clear that wipes every bit. Words that differ from a valid move in one field at a time, such as the opcode, the zero bits, the operation field or the strobe, are also sent. A design that ignores any of those fields would react to them.

// File: rtl/cp0_pkg.sv
package cp0_pkg;

    localparam logic [5:0] COP0_OPCODE = 6'b010000;
    localparam logic [4:0] EXC_RSVD    = 5'd10;

    typedef enum logic [4:0] {
        FN_READ32  = 5'b00000,
        FN_READ64  = 5'b00001,
        FN_WRITE32 = 5'b00100,
        FN_WRITE64 = 5'b00101
    } move_fn_e;

    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_COMPARE,
        TGT_STATUS,
        TGT_PRID,
        TGT_CORE_ID,
        TGT_THREAD_ID
    } cp0_tgt_e;

    typedef struct packed {
        logic       move;
        logic       is_write;
        logic       wide;
        logic [4:0] gpr;
        logic [4:0] creg;
        logic [2:0] sel;
    } move_dec_t;

endpackage

// File: rtl/cp0_decode.sv
module cp0_decode
    import cp0_pkg::*;
(
    input  logic        valid_i,
    input  logic [31:0] instr_i,
    output move_dec_t   dec_o
);
    logic [4:0] fn;
    logic       fn_known;

    assign fn = instr_i[25:21];

    always_comb begin
        fn_known = (fn == FN_READ32) || (fn == FN_READ64) ||
                   (fn == FN_WRITE32) || (fn == FN_WRITE64);
        dec_o.move     = valid_i && (instr_i[31:26] == COP0_OPCODE) &&
                         (instr_i[10:3] == 8'd0) && fn_known;
        dec_o.is_write = fn[2];
        dec_o.wide     = fn[0];
        dec_o.gpr      = instr_i[20:16];
        dec_o.creg     = instr_i[15:11];
        dec_o.sel      = instr_i[2:0];
    end
endmodule

// File: rtl/cp0_map.sv
module cp0_map
    import cp0_pkg::*;
(
    input  logic [4:0] creg_i,
    input  logic [2:0] sel_i,
    output cp0_tgt_e   tgt_o
);
    always_comb begin
        tgt_o = TGT_NONE;
        unique case ({creg_i, sel_i})
            {5'd11, 3'd0}: tgt_o = TGT_COMPARE;
            {5'd12, 3'd0}: tgt_o = TGT_STATUS;
            {5'd15, 3'd0}: tgt_o = TGT_PRID;
            {5'd15, 3'd6}: tgt_o = TGT_CORE_ID;
            {5'd15, 3'd7}: tgt_o = TGT_THREAD_ID;
            default:       tgt_o = TGT_NONE;
        endcase
    end
endmodule

// File: rtl/cp0_read_mux.sv
module cp0_read_mux
    import cp0_pkg::*;
#(
    parameter int unsigned       DATA_W   = 64,
    parameter int unsigned       REG_W    = 32,
    parameter logic [REG_W-1:0]  PRID_VAL = 32'h0000_0400
) (
    input  cp0_tgt_e             tgt_i,
    input  logic                 wide_i,
    input  logic [REG_W-1:0]     compare_i,
    input  logic [REG_W-1:0]     status_i,
    output logic [DATA_W-1:0]    value_o
);
    localparam int unsigned EXT_W = DATA_W - REG_W;

    logic [REG_W-1:0] word;

    always_comb begin
        unique case (tgt_i)
            TGT_COMPARE: word = compare_i;
            TGT_STATUS:  word = status_i;
            TGT_PRID:    word = PRID_VAL;
            default:     word = '0;
        endcase
        if (wide_i) begin
            value_o = {{EXT_W{1'b0}}, word};
        end else begin
            value_o = {{EXT_W{word[REG_W-1]}}, word};
        end
    end
endmodule

// File: rtl/cp0_regs_unit.sv
module cp0_regs_unit
    import cp0_pkg::*;
#(
    parameter int unsigned      DATA_W   = 64,
    parameter int unsigned      REG_W    = 32,
    parameter int unsigned      NUM_PEND = 8,
    parameter logic [REG_W-1:0] PRID_VAL = 32'h0000_0400
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 valid_i,
    input  logic [31:0]          instr_i,
    input  logic [DATA_W-1:0]    src_i,
    input  logic [NUM_PEND-1:0]  pend_set_i,
    output logic [DATA_W-1:0]    result_o,
    output logic                 gpr_we_o,
    output logic [4:0]           gpr_idx_o,
    output logic                 rsvd_exc_o,
    output logic [REG_W-1:0]     cause_o
);
    localparam int unsigned PEND_LSB = 8;
    localparam int unsigned CODE_LSB = 2;

    typedef struct packed {
        logic [REG_W-1:0]    compare;
        logic [REG_W-1:0]    status;
        logic [NUM_PEND-1:0] pend;
        logic [4:0]          code;
    } cp0_state_t;

    cp0_state_t  st_d, st_q;
    move_dec_t   dec;
    cp0_tgt_e    tgt;
    logic [DATA_W-1:0] rd_value;
    logic        mapped;
    logic        unused_src_hi;

    assign unused_src_hi = ^src_i[DATA_W-1:REG_W];

    cp0_decode i_decode (
        .valid_i (valid_i),
        .instr_i (instr_i),
        .dec_o   (dec)
    );

    cp0_map i_map (
        .creg_i (dec.creg),
        .sel_i  (dec.sel),
        .tgt_o  (tgt)
    );

    cp0_read_mux #(
        .DATA_W   (DATA_W),
        .REG_W    (REG_W),
        .PRID_VAL (PRID_VAL)
    ) i_read_mux (
        .tgt_i     (tgt),
        .wide_i    (dec.wide),
        .compare_i (st_q.compare),
        .status_i  (st_q.status),
        .value_o   (rd_value)
    );

    assign mapped = (tgt != TGT_NONE);

    always_comb begin
        st_d      = st_q;
        st_d.pend = st_q.pend | pend_set_i;
        if (dec.move && dec.is_write) begin
            unique case (tgt)
                TGT_COMPARE: begin
                    st_d.compare = src_i[REG_W-1:0];
                    st_d.pend[0] = 1'b0;
                end
                TGT_STATUS: st_d.status = src_i[REG_W-1:0];
                default: ;
            endcase
        end
        if (dec.move && !mapped) begin
            st_d.code = EXC_RSVD;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        gpr_we_o   = dec.move && !dec.is_write && mapped;
        rsvd_exc_o = dec.move && !mapped;
        gpr_idx_o  = dec.gpr;
        result_o   = gpr_we_o ? rd_value : '0;
        cause_o    = '0;
        cause_o[PEND_LSB +: NUM_PEND] = st_q.pend;
        cause_o[CODE_LSB +: 5]        = st_q.code;
    end
endmodule

// File: rtl/cp0_regs_checker.sv
module cp0_regs_checker #(
    parameter int unsigned DATA_W = 64,
    parameter int unsigned REG_W  = 32
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              valid_i,
    input logic [31:0]       instr_i,
    input logic [DATA_W-1:0] result_o,
    input logic              gpr_we_o,
    input logic              rsvd_exc_o,
    input logic [REG_W-1:0]  cause_o,
    input logic [REG_W-1:0]  st_compare,
    input logic [REG_W-1:0]  st_status
);
    logic cop_shape;
    logic wr_compare;

    assign cop_shape  = valid_i && (instr_i[31:26] == 6'b010000) && (instr_i[10:3] == 8'd0);
    assign wr_compare = cop_shape && (instr_i[25:21] == 5'b00100 || instr_i[25:21] == 5'b00101) &&
                        (instr_i[15:11] == 5'd11) && (instr_i[2:0] == 3'd0);

    p_idle_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !valid_i |-> (!rsvd_exc_o && !gpr_we_o));

    p_cmp_clear_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_compare |=> !cause_o[8]);

    p_exc_no_we_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsvd_exc_o |-> !gpr_we_o);

    p_exc_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsvd_exc_o |=> (st_status == $past(st_status) && st_compare == $past(st_compare)));

    p_exc_code_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rsvd_exc_o |=> (cause_o[6:2] == 5'd10));

    p_sext_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gpr_we_o && instr_i[25:21] == 5'b00000) |->
            (result_o[DATA_W-1:REG_W] == {(DATA_W-REG_W){result_o[REG_W-1]}}));

    p_write_no_we_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cop_shape && instr_i[23]) |-> !gpr_we_o);
endmodule

bind cp0_regs_unit cp0_regs_checker #(
    .DATA_W (DATA_W),
    .REG_W  (REG_W)
) i_checker (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .valid_i    (valid_i),
    .instr_i    (instr_i),
    .result_o   (result_o),
    .gpr_we_o   (gpr_we_o),
    .rsvd_exc_o (rsvd_exc_o),
    .cause_o    (cause_o),
    .st_compare (st_q.compare),
    .st_status  (st_q.status)
);

// File: tb/test_cp0_regs_unit.sv
`timescale 1ns/1ps
module test_cp0_regs_unit;

    logic        clk_i = 1'b0;
    logic        rst_ni = 1'b0;
    logic        valid_i = 1'b0;
    logic [31:0] instr_i = '0;
    logic [63:0] src_i = '0;
    logic [7:0]  pend_set_i = '0;
    logic [63:0] result_o;
    logic        gpr_we_o;
    logic [4:0]  gpr_idx_o;
    logic        rsvd_exc_o;
    logic [31:0] cause_o;

    always #10 clk_i = ~clk_i;

    cp0_regs_unit i_cp0_regs_unit (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .valid_i    (valid_i),
        .instr_i    (instr_i),
        .src_i      (src_i),
        .pend_set_i (pend_set_i),
        .result_o   (result_o),
        .gpr_we_o   (gpr_we_o),
        .gpr_idx_o  (gpr_idx_o),
        .rsvd_exc_o (rsvd_exc_o),
        .cause_o    (cause_o)
    );

    typedef struct {
        logic [63:0] res;
        logic        we;
        logic [4:0]  idx;
        logic        exc;
        logic [31:0] cause;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_checks = 0;
    int   n_errors = 0;
    bit   done = 1'b0;

    logic [31:0] m_cmp = '0, m_stat = '0;
    logic [7:0]  m_pend = '0;
    logic [4:0]  m_code = '0;

    function automatic logic [31:0] mk(input logic [4:0] fn, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [2:0] sel);
        return {6'b010000, fn, rt, rd, 8'd0, sel};
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [31:0] ins, input logic [63:0] src,
                         input logic [7:0] ps, input string tag);
        exp_t e;
        logic [4:0] fn, rd;
        logic [2:0] sel;
        logic is_mv, mapped, wr;
        logic [31:0] w;
        @(negedge clk_i);
        valid_i = v; instr_i = ins; src_i = src; pend_set_i = ps;
        fn = ins[25:21]; rd = ins[15:11]; sel = ins[2:0];
        is_mv = v && ins[31:26] == 6'b010000 && ins[10:3] == 8'd0 &&
                (fn == 5'd0 || fn == 5'd1 || fn == 5'd4 || fn == 5'd5);
        wr = fn[2];
        mapped = (rd == 5'd11 && sel == 3'd0) || (rd == 5'd12 && sel == 3'd0) ||
                 (rd == 5'd15 && (sel == 3'd0 || sel == 3'd6 || sel == 3'd7));
        w = (rd == 5'd11) ? m_cmp : (rd == 5'd12) ? m_stat :
            (rd == 5'd15 && sel == 3'd0) ? 32'h400 : 32'd0;
        e.we    = is_mv && !wr && mapped;
        e.exc   = is_mv && !mapped;
        e.idx   = ins[20:16];
        e.res   = !e.we ? 64'd0 : (fn[0] ? {32'd0, w} : {{32{w[31]}}, w});
        e.cause = {16'd0, m_pend, 1'b0, m_code, 2'b00};
        e.tag   = tag;
        q.push_back(e);
        m_pend = m_pend | ps;
        if (is_mv && wr && mapped && rd == 5'd11) begin m_cmp = src[31:0]; m_pend[0] = 1'b0; end
        if (is_mv && wr && mapped && rd == 5'd12) m_stat = src[31:0];
        if (e.exc) m_code = 5'd10;
    endtask

    initial begin : monitor
        exp_t e;
        forever begin
            @(negedge clk_i);
            #5;
            if (q.size() > 0) begin
                e = q.pop_front();
                chk({e.tag, " result"}, result_o, e.res);
                chk({e.tag, " we"}, {63'd0, gpr_we_o}, {63'd0, e.we});
                chk({e.tag, " exc"}, {63'd0, rsvd_exc_o}, {63'd0, e.exc});
                chk({e.tag, " cause"}, {32'd0, cause_o}, {32'd0, e.cause});
                if (e.we) chk({e.tag, " idx"}, {59'd0, gpr_idx_o}, {59'd0, e.idx});
            end
        end
    end

    initial begin : watchdog
        #4000000;
        if (!done) begin
            n_errors++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin : stim
        repeat (3) @(posedge clk_i);
        #3 chk("R9 reset cause", {32'd0, cause_o}, 64'd0);
        rst_ni = 1'b1;
        // R9: registers read zero after reset
        drive(1, mk(5'd1, 5'd3, 5'd11, 3'd0), 64'd0, 8'd0, "R9 compare after reset");
        drive(1, mk(5'd1, 5'd4, 5'd12, 3'd0), 64'd0, 8'd0, "R9 status after reset");
        // R2, R8, R10: Compare with bit 31 set
        drive(1, mk(5'd4, 5'd2, 5'd11, 3'd0), 64'hDEAD_BEEF_8000_1234, 8'd0, "R10 write compare no we");
        drive(1, mk(5'd0, 5'd7, 5'd11, 3'd0), 64'd0, 8'd0, "R8 read32 compare sext");
        drive(1, mk(5'd1, 5'd8, 5'd11, 3'd0), 64'd0, 8'd0, "R2 read64 compare zext");
        // R4: Status with junk in upper half
        drive(1, mk(5'd5, 5'd2, 5'd12, 3'd0), 64'hFFFF_0000_1357_2468, 8'd0, "R4 write64 status");
        drive(1, mk(5'd1, 5'd9, 5'd12, 3'd0), 64'd0, 8'd0, "R4 read64 status");
        drive(1, mk(5'd0, 5'd9, 5'd12, 3'd0), 64'd0, 8'd0, "R8 read32 status");
        // R5: identification reads
        drive(1, mk(5'd0, 5'd1, 5'd15, 3'd0), 64'd0, 8'd0, "R5 prid read32");
        drive(1, mk(5'd1, 5'd1, 5'd15, 3'd6), 64'd0, 8'd0, "R5 core id read");
        drive(1, mk(5'd1, 5'd1, 5'd15, 3'd7), 64'd0, 8'd0, "R5 thread id read");
        // R6: identification writes leave state unchanged
        drive(1, mk(5'd4, 5'd1, 5'd15, 3'd0), 64'hFFFF_FFFF_FFFF_FFFF, 8'd0, "R6 write prid");
        drive(1, mk(5'd5, 5'd1, 5'd15, 3'd7), 64'hFFFF_FFFF_FFFF_FFFF, 8'd0, "R6 write thread id");
        drive(1, mk(5'd1, 5'd1, 5'd12, 3'd0), 64'd0, 8'd0, "R6 status intact");
        drive(1, mk(5'd1, 5'd1, 5'd11, 3'd0), 64'd0, 8'd0, "R6 compare intact");
        // R7: unmapped read and write
        drive(1, mk(5'd0, 5'd5, 5'd9, 3'd0), 64'd0, 8'd0, "R7 unmapped read");
        drive(1, mk(5'd4, 5'd5, 5'd12, 3'd1), 64'h0000_0000_AAAA_5555, 8'd0, "R7 unmapped write");
        drive(1, mk(5'd1, 5'd5, 5'd12, 3'd0), 64'd0, 8'd0, "R7 status unchanged");
        drive(1, mk(5'd5, 5'd5, 5'd15, 3'd5), 64'd1, 8'd0, "R7 reg15 sel5 traps");
        // R1: near-miss words
        drive(1, mk(5'd4, 5'd1, 5'd12, 3'd0) | 32'h0000_0040, 64'h1111, 8'd0, "R1 bits10..3 nonzero");
        drive(1, {6'b010001, 26'd0} | mk(5'd4, 5'd1, 5'd12, 3'd0), 64'h2222, 8'd0, "R1 wrong opcode");
        drive(1, mk(5'd2, 5'd1, 5'd12, 3'd0), 64'h3333, 8'd0, "R1 unknown op field");
        drive(0, mk(5'd4, 5'd1, 5'd12, 3'd0), 64'h4444, 8'd0, "R1 valid low");
        drive(1, mk(5'd1, 5'd1, 5'd12, 3'd0), 64'd0, 8'd0, "R1 status untouched");
        // R3: pending bits
        drive(0, 32'd0, 64'd0, 8'h09, "R3 set pend 0 and 3");
        drive(0, 32'd0, 64'd0, 8'h00, "R3 pend sticky");
        drive(1, mk(5'd4, 5'd1, 5'd11, 3'd0), 64'h55, 8'h00, "R3 compare write clears bit0");
        drive(0, 32'd0, 64'd0, 8'h00, "R3 bit3 kept");
        drive(1, mk(5'd4, 5'd1, 5'd11, 3'd0), 64'h66, 8'h01, "R3 clear beats same-cycle set");
        drive(1, mk(5'd1, 5'd1, 5'd11, 3'd0), 64'd0, 8'h00, "R3 result after clash");
        @(negedge clk_i);
        valid_i = 1'b0; pend_set_i = '0;
        repeat (3) @(negedge clk_i);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule